// File: doc/BRIEF.md
# 8-bit ALU with status flags

This unit combines two 8-bit operands under a 3-bit operation code. It produces a result byte and a proposed set of status flags in the same cycle, with no register in between. The operations are add, subtract, increment, decrement and bitwise AND.

The flags are carry, zero, negative, two's-complement overflow, sign and a nibble-boundary half carry. On subtraction, carry and half carry act as borrows.

An 8-bit status register keeps the flags. It loads the proposed flags only on a clock edge where a legal operation is committed. Two more bits of that register, an interrupt-enable bit and a temporary bit, pass through the block unchanged. Their values are fixed by parameters at reset. The surrounding core presents operands and an operation code, reads `result` straight away, and raises `op_valid` in the cycle it wants the flags kept.

Top module: `alu8_core`

## Requirements
- R1: Operation code 0 (add) gives `result` = (opa + opb) mod 256, and carry (status bit 0) is 1 exactly when the true sum exceeds 255.
- R2: For add, half carry (status bit 5) is 1 exactly when the sum of the two low nibbles exceeds 15.
- R3: Operation code 1 (subtract) gives `result` = (opa − opb) mod 256, and carry is 1 exactly when opb > opa as unsigned values.
- R4: For subtract, half carry is 1 exactly when the low nibble of opb is greater than the low nibble of opa.
- R5: For every legal operation, zero (bit 1) is 1 exactly when `result` is 0, and negative (bit 2) equals `result` bit 7.
- R6: Overflow (bit 3) is 1 when the signed result of the operation falls outside −128..127. Sign (bit 4) equals negative XOR overflow.
- R7: Operation codes 2 (increment) and 3 (decrement) add or subtract one, wrapping modulo 256. They update zero, negative, overflow and sign, and keep the current carry and half carry.
- R8: Operation code 4 (AND) gives opa & opb and clears overflow. It keeps carry and half carry and updates zero, negative and sign.
- R9: `result` and `flags_next` follow the inputs in the same cycle. `status` takes `flags_next` only on a rising edge with `op_valid` high and is otherwise held.
- R10: Reset (synchronous, active high) loads interrupt-enable (bit 7) with `INIT_IEN`, temporary (bit 6) with `INIT_TMP`, and zeroes bits 5..0. Bits 7 and 6 never change after that.
- R11: Operation codes 5, 6 and 7 are not legal. They drive `result` to 0 and `flags_next` to the current `status`, and a committed illegal code leaves `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Commit the current operation's flags at the next rising edge |
| op_sel | input | 3 | Operation code: 0 add, 1 sub, 2 inc, 3 dec, 4 and |
| opa | input | 8 | First operand (minuend, or the only operand for inc/dec) |
| opb | input | 8 | Second operand (subtrahend for sub, ignored by inc/dec) |
| result | output | 8 | Combinational result |
| flags_next | output | 8 | Combinational proposed status: I T H S V N Z C from bit 7 down |
| status | output | 8 | Registered status register, same bit layout |

## Verification
`result` and `flags_next` are due in the cycle the inputs are applied. The bench drives them away from any clock edge with `op_valid` low and reads them one nanosecond later. It sweeps every operand pair for each legal code, comparing against an integer-width model.

`status` is due one edge after a commit. The driver task sets inputs on a falling edge and queues the status expected after the following rising edge. The monitor pops and compares one nanosecond after each rising edge. Commits with `op_valid` low and with illegal codes queue an unchanged status, which checks holding at the port.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_INC = 3'd2,
        OP_DEC = 3'd3,
        OP_AND = 3'd4
    } alu_op_e;

    localparam int NUM_LEGAL_OPS = 5;

    // Bit layout from MSB: ien tmp half sgn ovf neg zero carry
    typedef struct packed {
        logic ien;
        logic tmp;
        logic half;
        logic sgn;
        logic ovf;
        logic neg;
        logic zero;
        logic carry;
    } status_t;

    function automatic logic op_is_legal(input logic [2:0] code);
        return int'(code) < NUM_LEGAL_OPS;
    endfunction

    function automatic logic op_is_unary(input alu_op_e op);
        return (op == OP_INC) || (op == OP_DEC);
    endfunction

    function automatic logic op_is_sub(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_DEC);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   sum,
    output logic           cout,
    output logic           hout,
    output logic           vout
);
    localparam int HB = W / 2;

    logic           is_sub;
    logic [W-1:0]   rhs;
    logic [W-1:0]   rhs_x;
    logic [W:0]     wide;
    logic [HB:0]    low;

    always_comb begin
        is_sub = op_is_sub(op);
        rhs    = op_is_unary(op) ? W'(1) : b;
        // subtraction as a + ~rhs + 1; the carry-outs become borrows inverted
        rhs_x  = is_sub ? ~rhs : rhs;
        wide   = {1'b0, a} + {1'b0, rhs_x} + (W+1)'(is_sub);
        low    = {1'b0, a[HB-1:0]} + {1'b0, rhs_x[HB-1:0]} + (HB+1)'(is_sub);
        sum    = wide[W-1:0];
        cout   = wide[W] ^ is_sub;
        hout   = low[HB] ^ is_sub;
        vout   = (a[W-1] == rhs_x[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i] = a[i] & b[i];
    end
endmodule

// File: rtl/alu8_flag_merge.sv
module alu8_flag_merge
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   arith_sum,
    input  logic           arith_c,
    input  logic           arith_h,
    input  logic           arith_v,
    input  logic [W-1:0]   and_y,
    input  status_t        cur,
    output logic [W-1:0]   res,
    output status_t        nxt
);
    always_comb begin
        nxt = cur;
        res = '0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                res       = arith_sum;
                nxt.carry = arith_c;
                nxt.half  = arith_h;
                nxt.ovf   = arith_v;
            end
            OP_INC, OP_DEC: begin
                res       = arith_sum;
                nxt.ovf   = arith_v;
            end
            OP_AND: begin
                res       = and_y;
                nxt.ovf   = 1'b0;
            end
            default: begin
                res       = '0;
            end
        endcase
        if (op_is_legal(op)) begin
            nxt.zero = (res == '0);
            nxt.neg  = res[W-1];
            nxt.sgn  = nxt.neg ^ nxt.ovf;
        end
    end
endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
    import alu8_pkg::*;
#(
    parameter logic INIT_IEN = 1'b0,
    parameter logic INIT_TMP = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    commit,
    input  status_t nxt,
    output status_t status_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status_q     <= '0;
            status_q.ien <= INIT_IEN;
            status_q.tmp <= INIT_TMP;
        end else if (commit) begin
            status_q     <= nxt;
        end
    end

    // R9: without a commit the register keeps its contents
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !commit |=> status_q == $past(status_q));

    // R10: carried bits stay at their reset values
    p_it_fixed_r10: assert property (@(posedge clk) disable iff (rst)
        (status_q.ien == INIT_IEN) && (status_q.tmp == INIT_TMP));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int   DATA_W   = 8,
    parameter logic INIT_IEN = 1'b0,
    parameter logic INIT_TMP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [2:0]        op_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] result,
    output logic [7:0]        flags_next,
    output logic [7:0]        status
);
    alu_op_e           op;
    logic [DATA_W-1:0] arith_sum;
    logic              arith_c;
    logic              arith_h;
    logic              arith_v;
    logic [DATA_W-1:0] and_y;
    status_t           cur;
    status_t           nxt;
    logic              commit;

    assign op     = alu_op_e'(op_sel);
    assign commit = op_valid && op_is_legal(op_sel);

    alu8_addsub #(.W(DATA_W)) i_addsub (
        .op   (op),
        .a    (opa),
        .b    (opb),
        .sum  (arith_sum),
        .cout (arith_c),
        .hout (arith_h),
        .vout (arith_v)
    );

    alu8_logic #(.W(DATA_W)) i_logic (
        .a (opa),
        .b (opb),
        .y (and_y)
    );

    alu8_flag_merge #(.W(DATA_W)) i_merge (
        .op        (op),
        .arith_sum (arith_sum),
        .arith_c   (arith_c),
        .arith_h   (arith_h),
        .arith_v   (arith_v),
        .and_y     (and_y),
        .cur       (cur),
        .res       (result),
        .nxt       (nxt)
    );

    alu8_status_reg #(.INIT_IEN(INIT_IEN), .INIT_TMP(INIT_TMP)) i_sreg (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .nxt      (nxt),
        .status_q (cur)
    );

    assign flags_next = nxt;
    assign status     = cur;

    // R5: committed zero flag matches the result that produced it
    p_zero_r5: assert property (@(posedge clk) disable iff (rst)
        commit |=> cur.zero == ($past(result) == '0));

    // R6: committed sign is negative xor overflow
    p_sign_r6: assert property (@(posedge clk) disable iff (rst)
        commit |=> cur.sgn == (cur.neg ^ cur.ovf));

    // R7: inc/dec leave carry and half carry alone
    p_incdec_keep_r7: assert property (@(posedge clk) disable iff (rst)
        commit && op_is_unary(op) |=>
            (cur.carry == $past(cur.carry)) && (cur.half == $past(cur.half)));

    // R8: AND clears overflow
    p_and_no_ovf_r8: assert property (@(posedge clk) disable iff (rst)
        commit && (op == OP_AND) |=> !cur.ovf);

    // R11: an illegal code never changes the register
    p_illegal_hold_r11: assert property (@(posedge clk) disable iff (rst)
        op_valid && !op_is_legal(op_sel) |=> $stable(cur));
endmodule

// File: tb/test_alu8_core.sv
`timescale 1ns/100ps
module test_alu8_core;
    localparam logic IEN0 = 1'b1;
    localparam logic TMP0 = 1'b0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [2:0] op_sel = '0;
    logic [7:0] opa = '0;
    logic [7:0] opb = '0;
    logic [7:0] result;
    logic [7:0] flags_next;
    logic [7:0] status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] model_st;

    typedef struct { logic [7:0] st; string req; } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    alu8_core #(.DATA_W(8), .INIT_IEN(IEN0), .INIT_TMP(TMP0)) i_alu8_core (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .opa(opa), .opb(opb), .result(result), .flags_next(flags_next),
        .status(status)
    );

    // Model at integer width; status layout I T H S V N Z C
    function automatic void model(input int op, input int a, input int b,
                                  input logic [7:0] cur,
                                  output logic [7:0] r, output logic [7:0] f);
        int full, sa, sb, sr;
        logic c, h, v, n, z;
        c = cur[0]; h = cur[5]; v = 1'b0;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        sr = 0;
        full = 0;
        case (op)
            0: begin full = a + b; c = full > 255; h = ((a % 16) + (b % 16)) > 15; sr = sa + sb; end
            1: begin full = a - b; c = b > a; h = (b % 16) > (a % 16); sr = sa - sb; end
            2: begin full = a + 1; sr = sa + 1; end
            3: begin full = a - 1; sr = sa - 1; end
            4: begin full = a & b; sr = 0; end
            default: begin r = 8'h00; f = cur; return; end
        endcase
        r = 8'(full);
        if (op != 4) v = (sr > 127) || (sr < -128);
        n = r[7];
        z = (r == 8'h00);
        f = {cur[7], cur[6], h, n ^ v, v, n, z, c};
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0: return "R1/R2/R5/R6";
            1: return "R3/R4/R5/R6";
            2, 3: return "R7";
            4: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    // Driver: inputs at falling edge, expected status queued for after the next rising edge
    task automatic drive_op(input bit v, input int op, input int a, input int b,
                            input string req);
        logic [7:0] r, f;
        @(negedge clk);
        op_valid = v;
        op_sel   = 3'(op);
        opa      = 8'(a);
        opb      = 8'(b);
        model(op, a, b, model_st, r, f);
        if (v && op < 5) model_st = f;
        sb_q.push_back('{st: model_st, req: req});
    endtask

    // Monitor: compares status one ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check8(e.req, "status", status, e.st);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, f;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_st = {IEN0, TMP0, 6'b0};
        #0.5;
        check8("R10", "reset status", status, model_st);

        // Registered behaviour, including the worked examples
        drive_op(1, 0, 8'h38, 8'h2F, "R2");
        drive_op(1, 0, 8'h9C, 8'h64, "R1");
        drive_op(1, 2, 8'h7F, 0,     "R7");
        drive_op(1, 3, 8'h80, 0,     "R7");
        drive_op(0, 1, 8'h01, 8'h05, "R9");
        drive_op(1, 5, 8'h12, 8'h34, "R11");
        drive_op(1, 1, 8'h52, 8'h73, "R3");
        drive_op(1, 4, 8'hF0, 8'h8F, "R8");
        drive_op(1, 2, 8'hFF, 0,     "R7");
        drive_op(1, 1, 8'h9C, 8'h9C, "R5");
        drive_op(1, 1, 8'hA5, 8'h23, "R4");
        drive_op(1, 7, 8'h00, 8'h00, "R11");
        drive_op(1, 3, 8'h00, 0,     "R7");
        drive_op(1, 0, 8'h7F, 8'h01, "R6");
        drive_op(1, 6, 8'hAA, 8'h55, "R10");
        drive_op(0, 0, 0, 0, "R9");
        repeat (3) @(posedge clk);

        // Combinational sweep, op_valid low, sampled away from edges (R9)
        @(negedge clk);
        #0.3;
        op_valid = 1'b0;
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    if (op >= 5 && ((a % 17) != 0 || (b % 17) != 0)) continue;
                    op_sel = 3'(op);
                    opa    = 8'(a);
                    opb    = 8'(b);
                    #1;
                    model(op, a, b, model_st, r, f);
                    if (result !== r || flags_next !== f) begin
                        check8(req_of(op), "result", result, r);
                        check8(req_of(op), "flags_next", flags_next, f);
                    end else begin
                        n_checks++;
                    end
                end
            end
        end
        #0.5;
        check8("R9", "status after sweep", status, model_st);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule